// File: doc/BRIEF.md
# Banked Translation Base Register with Access Arbitration

This block holds a 64-bit translation-table base register in two banked copies, one for the secure world and one for the non-secure world. Each incoming access carries a direction (read or write), a width (one 32-bit word or the full 64 bits), the current privilege level (0 to 3), a security bit and a set of trap enables owned by the hypervisor level. The block settles every access in one step. It either completes the access, declares it undefined, or hands it to the hypervisor level together with a syndrome code. It returns exactly one response per accepted request.

Requests use a valid/ready handshake. `req_ready` is held high at all times, because each request is settled in the cycle it is offered. Responses come back as a one-cycle `rsp_valid` pulse in the following cycle and cannot be stalled. The consumer must therefore take each response on the cycle it appears.

Alongside the access path, a read-only decoder splits a chosen bank into its fields. The decoder handles both the short descriptor layout and the long descriptor layout, as selected by `fmt_long`. It also reports an address-size fault when a long-format base address reaches above 40 bits. Levels 1 and 2 always use the non-secure copy, which also serves as the common copy. Only level 3 can reach the secure copy.

Top module: `tbase_bank_ctl`

## Requirements
- R1: After reset both banks hold zero, `rsp_valid` is low and `req_ready` is high.
- R2: A request at level 0 gets status 1 (undefined) for every direction and width. It changes neither bank.
- R3: At level 1 with `el2_en` high, the access traps with status 2 in either of two cases: `trap_reg` is set, or the direction-matching enable is set (`trap_rd` for reads, `trap_wr` for writes). The syndrome is 0x03 for a 32-bit access and 0x04 for a 64-bit access. It is 0x00 on any response that is not a trap. With `el2_en` low, level 1 never traps.
- R4: Requests at levels 1 and 2 use the non-secure bank, and level 2 never traps. At level 3, `req_ns`=0 selects the secure bank and `req_ns`=1 selects the non-secure bank.
- R5: A write at level 3 with `req_ns`=0 is undefined (status 1) while `sec_wr_dis` is high. A read in the same condition completes. A non-secure write at level 3 is unaffected by `sec_wr_dis`.
- R6: A 32-bit write replaces bits [31:0] with `req_wlo` and keeps bits [63:32]. A 64-bit write stores `req_whi` in [63:32] and `req_wlo` in [31:0].
- R7: Read data holds the bank's bits [31:0] in `rsp_rdata[31:0]`. For a 64-bit read with `fmt_long`=1, bits [55:32] are also returned. All other `rsp_rdata` bits are zero, including [63:56] in every case and [63:32] in short format. Responses other than a completed read carry zero data.
- R8: In short format (`fmt_long`=0), the decoder presents bits [31:14] as base address bits [31:14], with all other base bits zero. It also presents:
  - outer attribute = bits [4:3];
  - implementation bit = bit 2;
  - inner attribute = {bit 0, bit 6}, so that bit 0 is the attribute's upper bit.
- R9: In short format, `dec_share` is 2'b00 (non-shareable) when bit 1 is 0, whatever bit 5 holds. When bit 1 is 1, it is 2'b10 (outer) if bit 5 is 0 and 2'b11 (inner) if bit 5 is 1. The code 2'b01 never appears.
- R10: In long format (`fmt_long`=1), the decoder presents ASID = bits [55:48], base address = bits [47:1] with base bit 0 zero, and common-not-private = bit 0. The short-only outputs read zero in long format, and the long-only outputs (ASID, common-not-private) read zero in short format.
- R11: `dec_size_fault` is 1 exactly when `fmt_long`=1 and bits [47:40] of the viewed bank are not all zero.
- R12: Each request accepted on a clock edge produces `rsp_valid` for exactly the next cycle, with status 0 = completed, 1 = undefined, 2 = trap. A write that completes is visible in the bank from that same cycle. A response with status 1 or 2 leaves both banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted; always high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_el | input | 2 | Privilege level of the requester |
| req_ns | input | 1 | Security bit; picks the bank at level 3 |
| req_wlo | input | 32 | Write data, lower word (first source) |
| req_whi | input | 32 | Write data, upper word (second source) |
| el2_en | input | 1 | Hypervisor level active for level-1 requests |
| trap_reg | input | 1 | Trap all level-1 accesses to this register |
| trap_rd | input | 1 | Trap level-1 reads |
| trap_wr | input | 1 | Trap level-1 writes |
| sec_wr_dis | input | 1 | Forbid secure writes at level 3 |
| fmt_long | input | 1 | 1 = long descriptor layout, 0 = short |
| dec_bank_ns | input | 1 | Bank shown by the decoder: 1 = non-secure, 0 = secure |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 undefined, 2 trap |
| rsp_syndrome | output | 8 | Trap syndrome code |
| rsp_rdata | output | 64 | Read data |
| dec_base | output | 48 | Decoded table base address |
| dec_asid | output | 8 | Decoded ASID (long format) |
| dec_inner | output | 2 | Inner cacheability (short format) |
| dec_outer | output | 2 | Outer cacheability (short format) |
| dec_share | output | 2 | Shareability: 00 none, 10 outer, 11 inner |
| dec_impdef | output | 1 | Implementation bit (short format) |
| dec_cnp | output | 1 | Common-not-private (long format) |
| dec_size_fault | output | 1 | Base address beyond 40 bits (long format) |

## Verification
A completed write and the field decoder act in the same cycle. When the decoder is pointed at the bank being written, its outputs must change on the very cycle the write's response pulse appears. The bench provokes this by writing a bank while `dec_bank_ns` selects that bank. It then samples the response and every decoded field together at the first sampling point after the accepting edge. Switching the view to the other bank afterwards confirms that the untouched bank still decodes to its earlier value.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_UNDEF = 2'd1,
    ST_TRAP  = 2'd2
  } status_e;

  localparam int SYN_W = 8;
  localparam logic [SYN_W-1:0] SYN_NARROW = 8'h03;
  localparam logic [SYN_W-1:0] SYN_WIDE   = 8'h04;

  // bank index: 0 secure, 1 non-secure (also the common copy)
  localparam logic BANK_SEC = 1'b0;
  localparam logic BANK_NS  = 1'b1;

  // field positions that downstream users decode
  localparam int SB_LO    = 14;
  localparam int SB_HI    = 31;
  localparam int LB_LO    = 1;
  localparam int LB_HI    = 47;
  localparam int FLT_LO   = 40;
  localparam int ASID_LSB = 48;
  localparam int BIT_IRH  = 0;
  localparam int BIT_IRL  = 6;
  localparam int BIT_NOS  = 5;
  localparam int BIT_ORH  = 4;
  localparam int BIT_ORL  = 3;
  localparam int BIT_IMP  = 2;
  localparam int BIT_SH   = 1;
  localparam int BIT_CNP  = 0;

  typedef struct packed {
    status_e          status;
    logic [SYN_W-1:0] syndrome;
    logic             bank;
    logic             commit;
  } verdict_t;

endpackage

// File: rtl/tbase_access_arb.sv
module tbase_access_arb
  import tbase_pkg::*;
(
  input  logic       req_write,
  input  logic       req_wide,
  input  logic [1:0] req_el,
  input  logic       req_ns,
  input  logic       el2_en,
  input  logic       trap_reg,
  input  logic       trap_rd,
  input  logic       trap_wr,
  input  logic       sec_wr_dis,
  output verdict_t   verdict
);

  logic dir_trap;

  always_comb begin
    dir_trap = req_write ? trap_wr : trap_rd;
    verdict          = '0;
    verdict.status   = ST_OK;
    verdict.bank     = BANK_NS;
    unique case (req_el)
      2'd0: verdict.status = ST_UNDEF;
      2'd1: begin
        // fixed order: register trap first, then the direction trap
        if (el2_en && trap_reg)      verdict.status = ST_TRAP;
        else if (el2_en && dir_trap) verdict.status = ST_TRAP;
      end
      2'd2: verdict.status = ST_OK;
      default: begin
        verdict.bank = req_ns ? BANK_NS : BANK_SEC;
        if (req_write && !req_ns && sec_wr_dis) verdict.status = ST_UNDEF;
      end
    endcase
    if (verdict.status == ST_TRAP)
      verdict.syndrome = req_wide ? SYN_WIDE : SYN_NARROW;
    verdict.commit = req_write && (verdict.status == ST_OK);
  end

endmodule

// File: rtl/tbase_bank_store.sv
module tbase_bank_store #(
  parameter int REG_W  = 64,
  parameter int WORD_W = 32,
  parameter int NBANKS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [$clog2(NBANKS)-1:0]     wr_bank,
  input  logic                          wr_wide,
  input  logic [WORD_W-1:0]             wr_lo,
  input  logic [REG_W-WORD_W-1:0]       wr_hi,
  output logic [NBANKS-1:0][REG_W-1:0]  bank_q
);

  localparam int BIDX_W = $clog2(NBANKS);

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    logic hit;
    assign hit = wr_en && (wr_bank == BIDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q[g] <= '0;
      end else if (hit) begin
        bank_q[g][WORD_W-1:0] <= wr_lo;
        if (wr_wide) bank_q[g][REG_W-1:WORD_W] <= wr_hi;
      end
    end
  end

endmodule

// File: rtl/tbase_field_view.sv
module tbase_field_view
  import tbase_pkg::*;
#(
  parameter int VIEW_W = 56,
  parameter int PA_W   = 48,
  parameter int ASID_W = 8
) (
  input  logic [VIEW_W-1:0] raw,
  input  logic              fmt_long,
  output logic [PA_W-1:0]   base,
  output logic [ASID_W-1:0] asid,
  output logic [1:0]        inner,
  output logic [1:0]        outer,
  output logic [1:0]        share,
  output logic              impdef,
  output logic              cnp,
  output logic              size_fault
);

  always_comb begin
    base       = '0;
    asid       = '0;
    inner      = '0;
    outer      = '0;
    share      = 2'b00;
    impdef     = 1'b0;
    cnp        = 1'b0;
    size_fault = 1'b0;
    if (fmt_long) begin
      base[LB_HI:LB_LO] = raw[LB_HI:LB_LO];
      asid              = raw[ASID_LSB +: ASID_W];
      cnp               = raw[BIT_CNP];
      size_fault        = |raw[LB_HI:FLT_LO];
    end else begin
      base[SB_HI:SB_LO] = raw[SB_HI:SB_LO];
      inner             = {raw[BIT_IRH], raw[BIT_IRL]};
      outer             = {raw[BIT_ORH], raw[BIT_ORL]};
      impdef            = raw[BIT_IMP];
      if (raw[BIT_SH]) share = raw[BIT_NOS] ? 2'b11 : 2'b10;
    end
  end

endmodule

// File: rtl/tbase_bank_ctl.sv
module tbase_bank_ctl
  import tbase_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int WORD_W = 32,
  parameter int PA_W   = 48,
  parameter int ASID_W = 8,
  parameter int NBANKS = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic                    req_wide,
  input  logic [1:0]              req_el,
  input  logic                    req_ns,
  input  logic [WORD_W-1:0]       req_wlo,
  input  logic [REG_W-WORD_W-1:0] req_whi,
  input  logic                    el2_en,
  input  logic                    trap_reg,
  input  logic                    trap_rd,
  input  logic                    trap_wr,
  input  logic                    sec_wr_dis,
  input  logic                    fmt_long,
  input  logic                    dec_bank_ns,
  output logic                    rsp_valid,
  output logic [1:0]              rsp_status,
  output logic [SYN_W-1:0]        rsp_syndrome,
  output logic [REG_W-1:0]        rsp_rdata,
  output logic [PA_W-1:0]         dec_base,
  output logic [ASID_W-1:0]       dec_asid,
  output logic [1:0]              dec_inner,
  output logic [1:0]              dec_outer,
  output logic [1:0]              dec_share,
  output logic                    dec_impdef,
  output logic                    dec_cnp,
  output logic                    dec_size_fault
);

  localparam int VIEW_W = ASID_LSB + ASID_W;

  verdict_t                   verdict;
  logic [NBANKS-1:0][REG_W-1:0] bank_q;
  logic [REG_W-1:0]           sel_raw;
  logic [REG_W-1:0]           rd_shaped;
  logic [REG_W-1:0]           view_raw;

  assign req_ready = 1'b1;

  tbase_access_arb u_arb (
    .req_write  (req_write),
    .req_wide   (req_wide),
    .req_el     (req_el),
    .req_ns     (req_ns),
    .el2_en     (el2_en),
    .trap_reg   (trap_reg),
    .trap_rd    (trap_rd),
    .trap_wr    (trap_wr),
    .sec_wr_dis (sec_wr_dis),
    .verdict    (verdict)
  );

  tbase_bank_store #(
    .REG_W  (REG_W),
    .WORD_W (WORD_W),
    .NBANKS (NBANKS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_valid && verdict.commit),
    .wr_bank (verdict.bank),
    .wr_wide (req_wide),
    .wr_lo   (req_wlo),
    .wr_hi   (req_whi),
    .bank_q  (bank_q)
  );

  // read shaping: upper word only in long format, reserved top byte zero
  assign sel_raw = bank_q[verdict.bank];
  always_comb begin
    rd_shaped = '0;
    rd_shaped[WORD_W-1:0] = sel_raw[WORD_W-1:0];
    if (req_wide && fmt_long)
      rd_shaped[VIEW_W-1:WORD_W] = sel_raw[VIEW_W-1:WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_status   <= ST_OK;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_status   <= verdict.status;
        rsp_syndrome <= verdict.syndrome;
        rsp_rdata    <= (!req_write && verdict.status == ST_OK) ? rd_shaped : '0;
      end else begin
        rsp_status   <= ST_OK;
        rsp_syndrome <= '0;
        rsp_rdata    <= '0;
      end
    end
  end

  assign view_raw = bank_q[dec_bank_ns];

  tbase_field_view #(
    .VIEW_W (VIEW_W),
    .PA_W   (PA_W),
    .ASID_W (ASID_W)
  ) u_view (
    .raw        (view_raw[VIEW_W-1:0]),
    .fmt_long   (fmt_long),
    .base       (dec_base),
    .asid       (dec_asid),
    .inner      (dec_inner),
    .outer      (dec_outer),
    .share      (dec_share),
    .impdef     (dec_impdef),
    .cnp        (dec_cnp),
    .size_fault (dec_size_fault)
  );

endmodule

// File: rtl/tbase_bank_ctl_chk.sv
module tbase_bank_ctl_chk #(
  parameter int REG_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_write,
  input logic             req_wide,
  input logic [1:0]       req_el,
  input logic             req_ns,
  input logic             sec_wr_dis,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [7:0]       rsp_syndrome,
  input logic             fmt_long,
  input logic [7:0]       dec_asid,
  input logic [1:0]       dec_share,
  input logic             dec_size_fault,
  input logic [REG_W-1:0] bank_s,
  input logic [REG_W-1:0] bank_ns
);

  // R2
  el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_el == 2'd0) |=> (rsp_valid && rsp_status == 2'd1));

  // R3
  trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_status == 2'd2) ?
      (rsp_syndrome == ($past(req_wide) ? 8'h04 : 8'h03)) : (rsp_syndrome == 8'h00));

  // R5
  sec_wr_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_el == 2'd3 && !req_ns && sec_wr_dis)
      |=> (rsp_status == 2'd1));

  // R6
  narrow_keeps_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_wide)
      |=> ($stable(bank_s[REG_W-1:32]) && $stable(bank_ns[REG_W-1:32])));

  // R9
  share_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_share != 2'b01);

  // R10
  short_no_asid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_long |-> (dec_asid == 8'h00));

  // R11
  fault_long_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_size_fault |-> fmt_long);

  // R12
  one_rsp_per_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R12
  no_rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R12
  reject_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> ($stable(bank_s) && $stable(bank_ns)));

endmodule

bind tbase_bank_ctl tbase_bank_ctl_chk #(.REG_W(REG_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_write      (req_write),
  .req_wide       (req_wide),
  .req_el         (req_el),
  .req_ns         (req_ns),
  .sec_wr_dis     (sec_wr_dis),
  .rsp_valid      (rsp_valid),
  .rsp_status     (rsp_status),
  .rsp_syndrome   (rsp_syndrome),
  .fmt_long       (fmt_long),
  .dec_asid       (dec_asid),
  .dec_share      (dec_share),
  .dec_size_fault (dec_size_fault),
  .bank_s         (bank_q[0]),
  .bank_ns        (bank_q[1])
);

// File: tb/tbase_bank_ctl_bench.sv
module tbase_bank_ctl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, req_ns = 1'b0;
  logic [1:0]  req_el = 2'd0;
  logic [31:0] req_wlo = '0, req_whi = '0;
  logic        el2_en = 1'b0, trap_reg = 1'b0, trap_rd = 1'b0, trap_wr = 1'b0;
  logic        sec_wr_dis = 1'b0, fmt_long = 1'b0, dec_bank_ns = 1'b1;
  logic        req_ready, rsp_valid;
  logic [1:0]  rsp_status;
  logic [7:0]  rsp_syndrome;
  logic [63:0] rsp_rdata;
  logic [47:0] dec_base;
  logic [7:0]  dec_asid;
  logic [1:0]  dec_inner, dec_outer, dec_share;
  logic        dec_impdef, dec_cnp, dec_size_fault;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  tbase_bank_ctl u_tbase_bank_ctl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_el(req_el), .req_ns(req_ns),
    .req_wlo(req_wlo), .req_whi(req_whi), .el2_en(el2_en), .trap_reg(trap_reg),
    .trap_rd(trap_rd), .trap_wr(trap_wr), .sec_wr_dis(sec_wr_dis),
    .fmt_long(fmt_long), .dec_bank_ns(dec_bank_ns), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata),
    .dec_base(dec_base), .dec_asid(dec_asid), .dec_inner(dec_inner),
    .dec_outer(dec_outer), .dec_share(dec_share), .dec_impdef(dec_impdef),
    .dec_cnp(dec_cnp), .dec_size_fault(dec_size_fault)
  );

  typedef struct packed {
    logic wr; logic wide; logic [1:0] el; logic ns;
    logic e2; logic tg; logic trd; logic twr; logic swd;
    logic [31:0] lo; logic [31:0] hi;
    logic [1:0] st; logic [7:0] syn;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b1,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h3456_7801,32'h00AB_0012, 2'd0,8'h00},
    '{1'b1,1'b1,2'd3,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_4000,32'h0011_0000, 2'd0,8'h00},
    '{1'b0,1'b1,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b0,1'b1,2'd1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd1,1'b0, 1'b1,1'b1,1'b0,1'b0,1'b0, 32'hFFFF_FFFF,32'h0, 2'd2,8'h03},
    '{1'b0,1'b1,2'd1,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0, 32'h0,32'h0, 2'd2,8'h04},
    '{1'b1,1'b1,2'd1,1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0, 32'h1111_2222,32'h0000_0033, 2'd0,8'h00},
    '{1'b0,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd1,1'b0, 1'b1,1'b0,1'b0,1'b1,1'b0, 32'hAAAA_AAAA,32'h0, 2'd2,8'h03},
    '{1'b1,1'b0,2'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'hBBBB_BBBB,32'h0, 2'd1,8'h00},
    '{1'b0,1'b1,2'd0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd1,8'h00},
    '{1'b1,1'b1,2'd2,1'b0, 1'b1,1'b1,1'b1,1'b1,1'b0, 32'hCAFE_0000,32'hFF00_0001, 2'd0,8'h00},
    '{1'b0,1'b1,2'd2,1'b0, 1'b1,1'b1,1'b1,1'b1,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'hDDDD_DDDD,32'h0, 2'd1,8'h00},
    '{1'b0,1'b1,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0055,32'h9999_9999, 2'd0,8'h00},
    '{1'b0,1'b1,2'd3,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd3,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b1, 32'h7777_0000,32'h0, 2'd0,8'h00},
    '{1'b0,1'b1,2'd1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd0,8'h00},
    '{1'b1,1'b0,2'd1,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0000_0001,32'h0, 2'd0,8'h00},
    '{1'b0,1'b1,2'd3,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0,32'h0, 2'd0,8'h00}
  };

  logic [63:0] mdl_s = '0, mdl_ns = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic wide, input logic [1:0] el,
                       input logic ns, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wide = wide; req_el = el; req_ns = ns;
    req_wlo = lo; req_whi = hi;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [63:0] shape(input logic [63:0] m, input logic wide, input logic lng);
    shape = {32'h0, m[31:0]};
    if (wide && lng) shape[55:32] = m[55:32];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R1 req_ready", {63'h0, req_ready}, 64'h1);
    chk("R1 ns bank base", {16'h0, dec_base}, 64'h0);
    dec_bank_ns = 1'b0; fmt_long = 1'b1; #1;
    chk("R1 sec bank asid/base", {8'h0, dec_asid, dec_base}, 64'h0);
    rst_n = 1'b1;

    // table walk in long format
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [63:0] m, expd;
      logic use_ns;
      v = VECS[i];
      el2_en = v.e2; trap_reg = v.tg; trap_rd = v.trd; trap_wr = v.twr; sec_wr_dis = v.swd;
      issue(v.wr, v.wide, v.el, v.ns, v.lo, v.hi);
      use_ns = (v.el == 2'd3) ? v.ns : 1'b1;
      m = use_ns ? mdl_ns : mdl_s;
      expd = (!v.wr && v.st == 2'd0) ? shape(m, v.wide, 1'b1) : 64'h0;
      chk($sformatf("R12 vec%0d valid", i), {63'h0, rsp_valid}, 64'h1);
      chk($sformatf("R2/R3/R5 vec%0d status", i), {62'h0, rsp_status}, {62'h0, v.st});
      chk($sformatf("R3 vec%0d syndrome", i), {56'h0, rsp_syndrome}, {56'h0, v.syn});
      chk($sformatf("R4/R7 vec%0d rdata", i), rsp_rdata, expd);
      if (v.wr && v.st == 2'd0) begin
        m[31:0] = v.lo;
        if (v.wide) m[63:32] = v.hi;
        if (use_ns) mdl_ns = m; else mdl_s = m;
      end
      @(negedge clk);
      chk($sformatf("R12 vec%0d pulse ends", i), {63'h0, rsp_valid}, 64'h0);
    end
    el2_en = 0; trap_reg = 0; trap_rd = 0; trap_wr = 0; sec_wr_dis = 0;

    // R6 secure upper word after narrow write survives
    issue(1'b0, 1'b1, 2'd3, 1'b0, 32'h0, 32'h0);
    chk("R6 secure upper kept", rsp_rdata, 64'h00AB_0012_0000_0055);

    // R8 short decode, written while decoder watches the same bank
    fmt_long = 1'b0; dec_bank_ns = 1'b1;
    issue(1'b1, 1'b1, 2'd3, 1'b1, 32'h1234_C076, 32'hDEAD_BEEF);
    chk("R8 base", {16'h0, dec_base}, 64'h0000_0000_1234_C000);
    chk("R8 inner/outer/imp", {59'h0, dec_inner, dec_outer, dec_impdef}, {59'h0, 2'b01, 2'b10, 1'b1});
    chk("R9 inner shareable", {62'h0, dec_share}, 64'h3);
    chk("R10 long fields zero in short", {55'h0, dec_asid, dec_cnp}, 64'h0);
    chk("R11 no fault in short", {63'h0, dec_size_fault}, 64'h0);
    dec_bank_ns = 1'b0; #1;
    chk("R8 other bank unchanged", {16'h0, dec_base}, 64'h0);
    dec_bank_ns = 1'b1;
    issue(1'b0, 1'b1, 2'd3, 1'b1, 32'h0, 32'h0);
    chk("R7 short wide read upper zero", rsp_rdata, 64'h0000_0000_1234_C076);

    // R9 shareability variants, R8 swapped inner bits
    issue(1'b1, 1'b0, 2'd3, 1'b1, 32'h0000_0020, 32'h0);
    chk("R9 nos ignored when not shareable", {62'h0, dec_share}, 64'h0);
    issue(1'b1, 1'b0, 2'd3, 1'b1, 32'h0000_0002, 32'h0);
    chk("R9 outer shareable", {62'h0, dec_share}, 64'h2);
    issue(1'b1, 1'b0, 2'd3, 1'b1, 32'h0000_0001, 32'h0);
    chk("R8 inner upper bit from bit0", {62'h0, dec_inner}, 64'h2);

    // R10 long decode
    fmt_long = 1'b1;
    issue(1'b1, 1'b1, 2'd1, 1'b0, 32'h8765_4321, 32'h5A3C_00C3);
    chk("R10 base", {16'h0, dec_base}, 64'h0000_00C3_8765_4320);
    chk("R10 asid/cnp", {55'h0, dec_asid, dec_cnp}, {55'h0, 8'h3C, 1'b1});
    chk("R10 short fields zero", {57'h0, dec_inner, dec_outer, dec_share, dec_impdef}, 64'h0);
    chk("R11 no fault", {63'h0, dec_size_fault}, 64'h0);
    issue(1'b0, 1'b1, 2'd2, 1'b0, 32'h0, 32'h0);
    chk("R7 long read", rsp_rdata, 64'h003C_00C3_8765_4321);

    // R11 size fault
    issue(1'b1, 1'b1, 2'd3, 1'b1, 32'h0, 32'h0000_0100);
    chk("R11 fault set", {63'h0, dec_size_fault}, 64'h1);
    fmt_long = 1'b0; #1;
    chk("R11 fault clear in short", {63'h0, dec_size_fault}, 64'h0);

    // R2 level-0 write must not land
    fmt_long = 1'b1;
    issue(1'b1, 1'b1, 2'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R2 undef", {62'h0, rsp_status}, 64'h1);
    chk("R2 bank intact", {63'h0, dec_size_fault}, 64'h1);
    chk("R2 bank intact base", {16'h0, dec_base}, 64'h0000_0100_0000_0000);

    summary();
  end

endmodule